// File: doc/BRIEF.md
# Key-Armed Watchdog Timer

This block is a watchdog timer attached to a small special-function-register write bus. After reset it does nothing. Software arms it by writing a two-byte key, `0x1E` and then `0xE1`, to register address `0xA6`. Once armed it counts machine-cycle ticks in a 14-bit counter. Software keeps it quiet by writing the same two-byte key again before the counter runs out.

When the counter reaches its all-ones value, the block raises a reset pulse and returns to its disarmed state. The pulse length depends on the clock-mode input. While armed, no register write can switch the watchdog off. Only the external reset or the watchdog's own overflow disarms it.

The key register is write-only, and the count has no read or load path. Inputs are the write strobe, address and data, a one-clock machine-cycle tick, and a clock-mode select. The single output is the reset pulse.

Top module: `lockWatchdog`

## Requirements
- R1: After reset `wdRstOut` is low, the watchdog is disarmed, and it raises no pulse however long the clock runs, until it is armed.
- R2: Two consecutive bus writes to address `0xA6`, first data `0x1E` and then data `0xE1`, arm the watchdog and zero its counter. With `cycTick` held high, the pulse rises on the clock edge that lies 16384 edges after the edge that took the `0xE1` write.
- R3: Repeating the same two-write key while the watchdog is armed zeroes the counter. The next pulse then rises 16384 edges after that `0xE1` write.
- R4: The counter advances only on clock edges where `cycTick` is high. With `cycTick` high on alternate edges starting on the edge after the key, the pulse rises 32766 edges after the `0xE1` write.
- R5: A `0x1E` write is forgotten if the next bus write is anything other than data `0xE1` to `0xA6`, including `0xE1` to a different address. A new `0x1E` write to `0xA6` restarts the key.
- R6: While armed, writes of any other values to `0xA6` do not disarm the watchdog, and the pulse still arrives on schedule.
- R7: On the clock after the counter holds all ones, `wdRstOut` rises, the watchdog disarms and the counter clears. No further pulse appears unless software arms the watchdog again.
- R8: The pulse lasts 98 clock cycles when `modeSix` is 1 and 196 cycles when it is 0. The mode is sampled on the overflow clock.
- R9: `wdRstOut` is low at every moment outside a pulse.
- R10: Key writes made while the pulse is high are ignored. They neither arm the watchdog nor leave a half-entered key behind.
- R11: Asserting `rstN` low clears, at once, the armed flag, the counter, any half-entered key and any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrWe | input | 1 | Register write strobe, one cycle per write |
| sfrAddr | input | 8 | Register write address |
| sfrWdata | input | 8 | Register write data |
| cycTick | input | 1 | Machine-cycle tick, high for one clock per machine cycle |
| modeSix | input | 1 | 1 selects the short pulse, 0 the long pulse |
| wdRstOut | output | 1 | Watchdog reset pulse, active high |

## Verification
The timer is first left unarmed for longer than a full count, which separates a truly inert block from one that counts anyway. It is then armed and serviced with a clean key, with keys broken by a foreign write, with a repeated first byte, and with stray values written to the key address. These cases separate a tracker that really requires adjacency from one that only looks for both bytes somewhere, and show that no write can disarm the timer.

A continuous tick and an alternating tick give different exact rise edges, which shows whether the count follows the tick or the clock. Both clock modes are used, so the two pulse widths are compared against each other. Key writes made during a pulse, an external reset in mid-count, an external reset in mid-key and an external reset in mid-pulse show that each disarming path leaves the timer silent.

// File: rtl/lockWdPkg.sv
package lockWdPkg;
  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic clrCnt;     // zero the machine-cycle counter
    logic loadPulse;  // start a reset pulse
  } wdStrobe_t;
endpackage

// File: rtl/lockWdCtrl.sv
module lockWdCtrl
  import lockWdPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 8'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWe,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  input  logic              atMax,
  input  logic              pulseBusy,
  output wdStrobe_t         strobe,
  output logic              armed
);
  logic keyHalf;
  logic addrHit;
  logic keyHit;
  logic ovf;

  // Key writes are only accepted outside a reset pulse.
  assign addrHit = sfrWe && (sfrAddr == KEY_ADDR) && !pulseBusy;
  assign keyHit  = addrHit && keyHalf && (sfrWdata == KEY_CLOSE);
  assign ovf     = armed && atMax;

  // Half-entered key: any write replaces it; only an opening byte sets it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyHalf <= 1'b0;
    end else if (pulseBusy) begin
      keyHalf <= 1'b0;
    end else if (sfrWe) begin
      keyHalf <= addrHit && (sfrWdata == KEY_OPEN);
    end
  end

  // Arm flag: overflow wins over a key completed on the same clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (ovf) begin
      armed <= 1'b0;
    end else if (keyHit) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    strobe.clrCnt    = keyHit || ovf;
    strobe.loadPulse = ovf;
  end
endmodule

// File: rtl/lockWdPath.sv
module lockWdPath
  import lockWdPkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int PULSE_SHORT = 98,
  parameter int PULSE_LONG  = 196
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic             armed,
  input  logic             cycTick,
  input  logic             modeSix,
  output logic             atMax,
  output logic             pulseBusy,
  output logic [CNT_W-1:0] count,
  output logic             wdRstOut
);
  localparam int PW = $clog2(PULSE_LONG + 1);
  localparam logic [PW-1:0] SHORT_LAST = PW'(PULSE_SHORT - 1);
  localparam logic [PW-1:0] LONG_LAST  = PW'(PULSE_LONG - 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [PW-1:0] pulseLeft;
  logic          pulseOn;

  assign atMax     = (count == CNT_TOP);
  assign pulseBusy = pulseOn;
  assign wdRstOut  = pulseOn;

  // Machine-cycle counter; stays at zero while disarmed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clrCnt) begin
      count <= '0;
    end else if (armed && cycTick) begin
      count <= count + 1'b1;
    end
  end

  // Pulse timer runs on every oscillator clock, independent of the tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn   <= 1'b0;
      pulseLeft <= '0;
    end else if (strobe.loadPulse) begin
      pulseOn   <= 1'b1;
      pulseLeft <= modeSix ? SHORT_LAST : LONG_LAST;
    end else if (pulseOn) begin
      if (pulseLeft == '0) begin
        pulseOn <= 1'b0;
      end else begin
        pulseLeft <= pulseLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockWatchdog.sv
module lockWatchdog
  import lockWdPkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int PULSE_SHORT = 98,
  parameter int PULSE_LONG  = 196
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sfrWe,
  input  logic [7:0] sfrAddr,
  input  logic [7:0] sfrWdata,
  input  logic       cycTick,
  input  logic       modeSix,
  output logic       wdRstOut
);
  wdStrobe_t        strobe;
  logic             armed;
  logic             atMax;
  logic             pulseBusy;
  logic [CNT_W-1:0] count;

  lockWdCtrl #(
    .ADDR_W(8),
    .DATA_W(8),
    .KEY_ADDR(8'hA6),
    .KEY_OPEN(8'h1E),
    .KEY_CLOSE(8'hE1)
  ) ctrl (
    .clk(clk),
    .rstN(rstN),
    .sfrWe(sfrWe),
    .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata),
    .atMax(atMax),
    .pulseBusy(pulseBusy),
    .strobe(strobe),
    .armed(armed)
  );

  lockWdPath #(
    .CNT_W(CNT_W),
    .PULSE_SHORT(PULSE_SHORT),
    .PULSE_LONG(PULSE_LONG)
  ) path (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .armed(armed),
    .cycTick(cycTick),
    .modeSix(modeSix),
    .atMax(atMax),
    .pulseBusy(pulseBusy),
    .count(count),
    .wdRstOut(wdRstOut)
  );
endmodule

// File: rtl/lockWdChecker.sv
module lockWdChecker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycTick,
  input logic             armed,
  input logic             clrCnt,
  input logic [CNT_W-1:0] count,
  input logic             wdRstOut
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> count == '0); // R1

  AST_ARMED_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    armed && count != CNT_TOP |=> armed); // R6

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    armed && !cycTick && !clrCnt |=> $stable(count)); // R4

  AST_OVERFLOW_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    armed && count == CNT_TOP |=> wdRstOut && !armed); // R7

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRstOut) |-> $past(armed && count == CNT_TOP)); // R9

  AST_PULSE_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    wdRstOut |=> !armed); // R10
endmodule

bind lockWatchdog lockWdChecker #(.CNT_W(CNT_W)) chk (
  .clk(clk),
  .rstN(rstN),
  .cycTick(cycTick),
  .armed(armed),
  .clrCnt(strobe.clrCnt),
  .count(count),
  .wdRstOut(wdRstOut)
);

// File: tb/lockWatchdog_test.sv
`timescale 1ns/1ps
module lockWatchdog_test;
  localparam int FULL = 16384;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sfrWe = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic [7:0] sfrWdata = 8'h00;
  logic cycTick = 1'b1;
  logic modeSix = 1'b0;
  logic wdRstOut;

  int edgeNo = 0;
  int checks = 0;
  int fails = 0;
  int pulseCount = 0;
  bit done = 1'b0;

  int expRise[$];
  int expWidth[$];
  string expTag[$];

  lockWatchdog uut (
    .clk(clk), .rstN(rstN), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .cycTick(cycTick), .modeSix(modeSix),
    .wdRstOut(wdRstOut)
  );

  always #4 clk = ~clk;
  always @(posedge clk) edgeNo <= edgeNo + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: one write per clock, launched at a falling edge.
  task automatic busWrite(input logic [7:0] a, input logic [7:0] d, output int takenAt);
    sfrWe = 1'b1; sfrAddr = a; sfrWdata = d;
    takenAt = edgeNo + 1;
    @(negedge clk);
    sfrWe = 1'b0;
  endtask

  task automatic sendKey(output int closeAt);
    int t;
    busWrite(8'hA6, 8'h1E, t);
    busWrite(8'hA6, 8'hE1, closeAt);
  endtask

  task automatic expectPulse(input int rise, input int width, input string tag);
    expRise.push_back(rise);
    expWidth.push_back(width);
    expTag.push_back(tag);
  endtask

  task automatic waitHigh;
    while (!wdRstOut) @(negedge clk);
  endtask

  // Monitor: measures each pulse and compares it with the queued expectation.
  logic prevOut = 1'b0;
  int riseAt = 0;
  int width = 0;
  always @(negedge clk) begin
    if (wdRstOut && !prevOut) begin
      riseAt = edgeNo; width = 1; pulseCount++;
    end else if (wdRstOut) begin
      width++;
    end else if (prevOut) begin
      if (expRise.size() == 0) begin
        check(1'b0, "R9 unexpected pulse at edge", riseAt, -1);
      end else begin
        int r, w;
        string tg;
        r = expRise.pop_front(); w = expWidth.pop_front(); tg = expTag.pop_front();
        check(riseAt == r, {tg, " rise edge"}, riseAt, r);
        if (w >= 0) check(width == w, {"R8 width ", tg}, width, w);
      end
    end
    prevOut = wdRstOut;
  end

  initial begin
    int s, s2, t, base;
    repeat (3) @(negedge clk);
    check(wdRstOut == 1'b0, "R1 out during reset", wdRstOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(wdRstOut == 1'b0, "R1 out after reset", wdRstOut, 0);

    // R1: never armed, must stay silent beyond one full count
    repeat (16500) @(negedge clk);
    check(pulseCount == 0, "R1 pulses while unarmed", pulseCount, 0);

    // R2/R3: arm, service, overflow in long mode
    modeSix = 1'b0;
    sendKey(s);
    repeat (10000) @(negedge clk);
    sendKey(s2);
    expectPulse(s2 + FULL, 196, "R3");
    waitHigh();
    // R10: key during the pulse is ignored
    sendKey(t);
    base = pulseCount;
    repeat (16500) @(negedge clk);
    check(pulseCount == base, "R7 R10 pulses after overflow", pulseCount, base);
    check(wdRstOut == 1'b0, "R9 out idle", wdRstOut, 0);

    // R5/R6: broken key and stray values do not service or disarm
    modeSix = 1'b1;
    sendKey(s);
    expectPulse(s + FULL, 98, "R5 R6 R2");
    busWrite(8'hA6, 8'h1E, t);
    busWrite(8'hA5, 8'hE1, t);
    busWrite(8'hA6, 8'hE1, t);
    busWrite(8'hA6, 8'h00, t);
    busWrite(8'hA6, 8'hFF, t);
    repeat (16500) @(negedge clk);

    // R5: repeated opening byte restarts the key and services
    modeSix = 1'b0;
    sendKey(s);
    repeat (100) @(negedge clk);
    busWrite(8'hA6, 8'h1E, t);
    busWrite(8'hA6, 8'h1E, t);
    busWrite(8'hA6, 8'hE1, s2);
    expectPulse(s2 + FULL, 196, "R5 restart");
    repeat (16600) @(negedge clk);

    // R4: tick on alternate edges
    modeSix = 1'b1;
    sendKey(s);
    expectPulse(s + 2 * FULL - 2, 98, "R4");
    cycTick = 1'b1;
    repeat (32900) begin
      @(negedge clk);
      cycTick = ~cycTick;
    end
    cycTick = 1'b1;
    repeat (20) @(negedge clk);

    // R11: reset mid-count and mid-key
    sendKey(s);
    repeat (5000) @(negedge clk);
    busWrite(8'hA6, 8'h1E, t);
    rstN = 1'b0;
    @(negedge clk);
    check(wdRstOut == 1'b0, "R11 out in reset", wdRstOut, 0);
    rstN = 1'b1;
    busWrite(8'hA6, 8'hE1, t);
    base = pulseCount;
    repeat (16500) @(negedge clk);
    check(pulseCount == base, "R11 silent after reset", pulseCount, base);

    // R11: reset mid-pulse
    modeSix = 1'b0;
    sendKey(s);
    expectPulse(s + FULL, -1, "R11 cut");
    waitHigh();
    repeat (3) @(negedge clk);
    #2 rstN = 1'b0;
    @(negedge clk);
    check(wdRstOut == 1'b0, "R11 pulse cleared", wdRstOut, 0);
    rstN = 1'b1;
    base = pulseCount;
    repeat (300) @(negedge clk);
    check(pulseCount == base, "R11 no pulse after cut", pulseCount, base);
    check(expRise.size() == 0, "R7 missing pulses", expRise.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", edgeNo, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule